// File: doc/BRIEF.md
# Configurable PLD Output Macrocell

This block is the per-output cell that sits between one sum-of-products result of a programmable logic array and its I/O pin. It turns the sum into a pin value and an output enable, and it hands one selected signal back to the array as feedback. Configuration bits choose the operating mode. The cell can run combinationally or through a D flip-flop, with either output polarity. The flip-flop has a global asynchronous clear term and a global synchronous preset term. Its clock comes from either the dedicated clock pin or a product-term clock, with a selectable edge.

The cell runs inside a synchronous chip. It is clocked by the system clock `clk`. The clock pin and the clock product term are treated as sampled levels. The flip-flop loads on a system clock edge at which the selected clock signal, after polarity, is high and was low on the previous sample. All ports are plain control and data levels. No stream or handshake is involved, so no back-pressure rules apply.

Top module: `pld_macrocell`

## Requirements
- R1: With `cfg_registered`=0, `pin_out` equals `sum_term` XOR `cfg_invert` in the same cycle.
- R2: With `cfg_registered`=1, `pin_out` equals the stored bit XOR `cfg_invert`. The stored bit loads `sum_term` only at a detected clock edge and holds its value between edges.
- R3: The effective clock is (`cfg_clk_from_term` ? `clk_term` : `clk_pin`) XOR `cfg_clk_invert`. The stored bit updates on the first `clk` rising edge at which the effective clock is 1 after having been 0. The unselected clock source and falling effective edges have no effect.
- R4: While `aclr_term` is 1, the stored bit reads 0 at once, without waiting for a clock. It stays 0 after release until the next effective clock edge.
- R5: If `sp_term` is 1 at an effective clock edge and `aclr_term` is 0, the stored bit becomes 1, whatever `sum_term` is.
- R6: If `aclr_term` and `sp_term` are both 1 at an effective clock edge, the clear wins and the stored bit is 0.
- R7: `pin_oe` follows `oe_term` in the same cycle.
- R8: `cfg_fb_sel` encodes the feedback as follows: 2'b00 gives the stored bit, 2'b01 gives `sum_term`, and 2'b10 or 2'b11 gives `pin_in`. Feedback is taken before the output inversion.
- R9: After reset the stored bit is 0. An effective clock that is already high when reset is released does not count as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_registered | input | 1 | 1 selects the flip-flop path, 0 the combinational path |
| cfg_invert | input | 1 | 1 inverts the pin output |
| cfg_clk_from_term | input | 1 | 1 clocks from the product term, 0 from the clock pin |
| cfg_clk_invert | input | 1 | 1 inverts the selected clock source |
| cfg_fb_sel | input | 2 | Feedback source select |
| sum_term | input | 1 | Sum-of-products result |
| oe_term | input | 1 | Output-enable product term for this cell |
| aclr_term | input | 1 | Global asynchronous clear term |
| sp_term | input | 1 | Global synchronous preset term |
| clk_pin | input | 1 | Dedicated clock pin level |
| clk_term | input | 1 | Clock product-term level |
| pin_in | input | 1 | Value read back from the I/O pad |
| pin_out | output | 1 | Value driven toward the pad |
| pin_oe | output | 1 | Pad output enable |
| fb_out | output | 1 | Feedback returned to the array |

## Verification
Four properties are checked on every cycle. The stored bit stays stable when no edge is detected and no clear is active. Two detected edges never occur on consecutive cycles. A preset edge leaves the bit at 1. An active clear drives the registered output to its inactive level. The bench scenarios are the only evidence for other behaviour. Those scenarios cover the choice of clock source and edge polarity, the suppression of an edge that is already high at reset, feedback taken ahead of the inversion, and the precedence of clear over preset at a shared edge.

// File: rtl/mcell_pkg.sv
package mcell_pkg;

  typedef enum logic [1:0] {
    FB_REG     = 2'b00,
    FB_SUM     = 2'b01,
    FB_PIN     = 2'b10,
    FB_PIN_ALT = 2'b11
  } fb_sel_e;

  typedef struct packed {
    logic    registered;
    logic    invert;
    logic    clk_from_term;
    logic    clk_invert;
    fb_sel_e fb_sel;
  } mcell_cfg_t;

endpackage

// File: rtl/mcell_clk_select.sv
module mcell_clk_select #(
  parameter bit PREV_RESET = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_pin,
  input  logic clk_term,
  input  logic use_term,
  input  logic invert,
  output logic fire
);

  logic eff_clk;
  logic prev_clk;

  always_comb begin
    eff_clk = (use_term ? clk_term : clk_pin) ^ invert;
  end

  // History resets high so a level already high at reset release is no edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_clk <= PREV_RESET;
    else        prev_clk <= eff_clk;
  end

  assign fire = eff_clk & ~prev_clk;

  // R3: a detected edge needs a low sample first, so edges never repeat back to back
  a_r3_no_double_fire: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);

endmodule

// File: rtl/mcell_reg.sv
module mcell_reg #(
  parameter bit CLEAR_VAL  = 1'b0,
  parameter bit PRESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic d,
  input  logic sp,
  input  logic aclr,
  output logic q_o
);

  logic q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= CLEAR_VAL;
    else if (aclr) q <= CLEAR_VAL;
    else if (fire) q <= sp ? PRESET_VAL : d;
  end

  // Clear acts on the visible value without waiting for a clock.
  assign q_o = aclr ? CLEAR_VAL : q;

  // R2: without an edge or a clear the stored bit holds
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && !aclr) |=> $stable(q));

  // R5: a preset edge without clear sets the bit
  a_r5_preset_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && sp && !aclr) |=> (q_o == PRESET_VAL || aclr));

endmodule

// File: rtl/mcell_out_stage.sv
module mcell_out_stage
  import mcell_pkg::*;
(
  input  logic    registered,
  input  logic    invert,
  input  fb_sel_e fb_sel,
  input  logic    q,
  input  logic    sum,
  input  logic    pin_in,
  output logic    pin_out,
  output logic    fb
);

  logic pre_inv;

  always_comb begin
    pre_inv = registered ? q : sum;
    pin_out = pre_inv ^ invert;
    unique case (fb_sel)
      FB_REG:  fb = q;
      FB_SUM:  fb = sum;
      default: fb = pin_in;
    endcase
  end

endmodule

// File: rtl/pld_macrocell.sv
module pld_macrocell
  import mcell_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_registered,
  input  logic       cfg_invert,
  input  logic       cfg_clk_from_term,
  input  logic       cfg_clk_invert,
  input  logic [1:0] cfg_fb_sel,
  input  logic       sum_term,
  input  logic       oe_term,
  input  logic       aclr_term,
  input  logic       sp_term,
  input  logic       clk_pin,
  input  logic       clk_term,
  input  logic       pin_in,
  output logic       pin_out,
  output logic       pin_oe,
  output logic       fb_out
);

  mcell_cfg_t cfg;
  logic       fire;
  logic       q;

  always_comb begin
    cfg.registered    = cfg_registered;
    cfg.invert        = cfg_invert;
    cfg.clk_from_term = cfg_clk_from_term;
    cfg.clk_invert    = cfg_clk_invert;
    cfg.fb_sel        = fb_sel_e'(cfg_fb_sel);
  end

  mcell_clk_select u_clk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_pin  (clk_pin),
    .clk_term (clk_term),
    .use_term (cfg.clk_from_term),
    .invert   (cfg.clk_invert),
    .fire     (fire)
  );

  mcell_reg u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (fire),
    .d     (sum_term),
    .sp    (sp_term),
    .aclr  (aclr_term),
    .q_o   (q)
  );

  mcell_out_stage u_out (
    .registered (cfg.registered),
    .invert     (cfg.invert),
    .fb_sel     (cfg.fb_sel),
    .q          (q),
    .sum        (sum_term),
    .pin_in     (pin_in),
    .pin_out    (pin_out),
    .fb         (fb_out)
  );

  assign pin_oe = oe_term;

  // R6: clear dominates, so a registered output shows its inactive level
  a_r6_clear_dominates: assert property (@(posedge clk) disable iff (!rst_n)
    (aclr_term && cfg_registered) |-> (pin_out == cfg_invert));

endmodule

// File: tb/pld_macrocell_test.sv
module pld_macrocell_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_registered = 1'b1, cfg_invert = 1'b0;
  logic cfg_clk_from_term = 1'b0, cfg_clk_invert = 1'b0;
  logic [1:0] cfg_fb_sel = 2'b00;
  logic sum_term = 1'b1, oe_term = 1'b0, aclr_term = 1'b0, sp_term = 1'b0;
  logic clk_pin = 1'b1, clk_term = 1'b0, pin_in = 1'b0;
  logic pin_out, pin_oe, fb_out;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pld_macrocell uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_registered(cfg_registered), .cfg_invert(cfg_invert),
    .cfg_clk_from_term(cfg_clk_from_term), .cfg_clk_invert(cfg_clk_invert),
    .cfg_fb_sel(cfg_fb_sel), .sum_term(sum_term), .oe_term(oe_term),
    .aclr_term(aclr_term), .sp_term(sp_term), .clk_pin(clk_pin),
    .clk_term(clk_term), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .fb_out(fb_out)
  );

  // {invert, fb_sel[1:0], sum, pin_in, oe, exp_out, exp_fb, exp_oe}
  localparam int NVEC = 8;
  localparam logic [8:0] VECS [NVEC] = '{
    9'b0_01_1_0_1_1_1_1,
    9'b1_01_1_0_0_0_1_0,
    9'b0_01_0_1_1_0_0_1,
    9'b1_01_0_1_1_1_0_1,
    9'b0_10_0_1_0_0_1_0,
    9'b1_10_1_0_0_0_0_0,
    9'b0_11_1_1_1_1_1_1,
    9'b1_00_1_1_1_0_0_1
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R9: effective clock high through reset must not load sum_term=1
    step(); step();
    rst_n = 1'b1;
    step(); step(); step();
    chk("R9 reset pin_out", pin_out, 1'b0);
    chk("R9 reset feedback", fb_out, 1'b0);

    // R1 R7 R8: combinational table, clk_pin held high so no edges occur
    cfg_registered = 1'b0;
    for (int i = 0; i < NVEC; i++) begin
      {cfg_invert, cfg_fb_sel, sum_term, pin_in, oe_term} = VECS[i][8:3];
      #1;
      chk("R1 comb pin_out", pin_out, VECS[i][2]);
      chk("R8 feedback select", fb_out, VECS[i][1]);
      chk("R7 pin_oe", pin_oe, VECS[i][0]);
    end

    // R2: registered load and hold
    cfg_registered = 1'b1; cfg_invert = 1'b0; cfg_fb_sel = 2'b00; sum_term = 1'b1;
    clk_pin = 1'b0; step();
    clk_pin = 1'b1; step();
    chk("R2 load on edge", pin_out, 1'b1);
    chk("R2 reg feedback", fb_out, 1'b1);
    clk_pin = 1'b0; sum_term = 1'b0; step(); step();
    chk("R2 hold between edges", pin_out, 1'b1);
    cfg_invert = 1'b1; #1;
    chk("R8 inverted pin_out", pin_out, 1'b0);
    chk("R8 feedback before inversion", fb_out, 1'b1);
    cfg_invert = 1'b0;

    // R3: inverted pin clock, falling pin edge loads
    clk_pin = 1'b1; cfg_clk_invert = 1'b1; step();
    chk("R3 polarity switch no edge", pin_out, 1'b1);
    clk_pin = 1'b0; step();
    chk("R3 inverted edge loads", pin_out, 1'b0);
    sum_term = 1'b1; clk_pin = 1'b1; step();
    chk("R3 wrong edge ignored", pin_out, 1'b0);

    // R3: product-term clock, pin ignored
    cfg_clk_from_term = 1'b1; cfg_clk_invert = 1'b0; clk_term = 1'b0; step();
    clk_pin = 1'b0; step();
    clk_pin = 1'b1; step();
    chk("R3 unselected pin ignored", pin_out, 1'b0);
    clk_term = 1'b1; step();
    chk("R3 term edge loads", pin_out, 1'b1);
    clk_term = 1'b0; step();

    // R4: asynchronous clear
    aclr_term = 1'b1; #1;
    chk("R4 clear immediate", pin_out, 1'b0);
    step();
    aclr_term = 1'b0; step();
    chk("R4 stays clear", pin_out, 1'b0);
    chk("R4 feedback clear", fb_out, 1'b0);

    // R5: synchronous preset overrides sum
    sp_term = 1'b1; sum_term = 1'b0; clk_term = 1'b1; step();
    chk("R5 preset sets", pin_out, 1'b1);
    sp_term = 1'b0; clk_term = 1'b0; step();
    chk("R5 preset retained", pin_out, 1'b1);

    // R6: clear beats preset at an edge
    aclr_term = 1'b1; sp_term = 1'b1; clk_term = 1'b1; step();
    chk("R6 clear wins", pin_out, 1'b0);
    aclr_term = 1'b0; sp_term = 1'b0; step();
    chk("R6 zero after release", pin_out, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule